// File: doc/BRIEF.md
# I2C SCL Rate Prescaler

This block derives the serial clock timing of an I2C master from one system clock. A 7-bit clock setting holds a power-of-two exponent and a linear multiplier. A first divider produces a sampling strobe at the system clock divided by two to the exponent. A second stage counts those strobes to build an SCL period of ten times (multiplier + 1) sampling ticks. The low half and the high half of the period are equal.

The surrounding controller keeps the prescaler enabled and raises `run` while it owns the bus. It uses `samp_tick` to pace its SDA sampling, and the one-clock `scl_fall` and `scl_rise` strobes to launch and capture data. SCL rests high whenever no transfer is in progress.

A new setting can be written at any time and reads back at once. The counters pick it up only at the end of a high phase, or while SCL is idle, so a phase that has started always runs its full length. After reset the setting is computed from two parameters, the system clock rate and the wanted SCL rate, so that a standard-mode bus runs at or just below the target.

Top module: `scl_rate_gen`

## Requirements
- R1: The clock setting register holds the exponent N in bits 2:0 and the multiplier M in bits 6:3. A write with `cfg_we` high stores `cfg_wdata[6:0]`, and `cfg_rdata` shows the stored value from the next cycle on. Bit 7 is ignored on write and always reads 0.
- R2: While `enable` is high, `samp_tick` is high for one clock in every 2^N clocks. It is never high while `enable` is low.
- R3: While running, each SCL low phase and each high phase lasts 5*(M+1) sampling ticks, which is 5*(M+1)*2^N clocks. A full SCL period therefore lasts 10*(M+1)*2^N clocks.
- R4: With `run` low, SCL stays high. When `run` is high, SCL falls at the next sampling tick. `run` is looked at again only at the end of each high phase, where a low value returns SCL to idle high.
- R5: A setting written during a transfer changes no phase already in progress. The new N and M govern timing from the next period boundary (the end of a high phase). While SCL is idle, a new setting is picked up one clock after it is written.
- R6: With `enable` low, both counters clear and `scl_o` is high from the next clock on.
- R7: The reset value of the setting uses the smallest N for which M fits in 4 bits, with M = ceil(SYSCLK_HZ / 2^N / (10*SCL_HZ)) - 1. For the default 50 MHz / 100 kHz this is N=2, M=12, which reads as 0x62.
- R8: `scl_fall` and `scl_rise` are each high for exactly the one clock just before `scl_o` falls or rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low clears the prescaler |
| run | input | 1 | Transfer in progress; high makes SCL toggle |
| cfg_we | input | 1 | Write strobe for the clock setting |
| cfg_wdata | input | 8 | Clock setting write data |
| cfg_rdata | output | 8 | Stored clock setting, bit 7 reads 0 |
| samp_tick | output | 1 | Sampling strobe, one clock every 2^N clocks |
| scl_o | output | 1 | Generated serial clock level |
| scl_rise | output | 1 | Strobe in the clock before SCL rises |
| scl_fall | output | 1 | Strobe in the clock before SCL falls |

## Verification
The bench targets the extremes of both fields. N=0 with M=0 gives a five-clock phase, where an off-by-one in the tick comparison would show as a 4- or 6-clock phase. N=7 with M=15 gives a phase of more than ten thousand clocks, where a counter one bit too narrow would wrap and shorten it. It writes a new setting partway through a low phase. A design that applied the write at once would shorten or stretch that phase, instead of holding it to 120 clocks and switching at the next period boundary. It also stops and restarts `run`, and drops `enable` inside a low phase. A design that did not clear there would leave SCL stuck low, or give a first phase of the wrong length afterwards.

// File: rtl/scl_prescale_pkg.sv
package scl_prescale_pkg;

  // Field layout of the clock setting: decoded by the divider stages.
  localparam int EXP_W  = 3;
  localparam int MUL_W  = 4;
  localparam int CCR_W  = EXP_W + MUL_W;
  // Sampling counter must reach 2^(2^EXP_W - 1) - 1.
  localparam int SAMP_W = (1 << EXP_W) - 1;
  // Phase counter must reach 5 * 2^MUL_W - 1.
  localparam int PH_W   = $clog2(5 * (1 << MUL_W));

  typedef struct packed {
    logic [MUL_W-1:0] mul;
    logic [EXP_W-1:0] exp;
  } ccr_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Last count value of the sampling divider for exponent e.
  function automatic logic [SAMP_W-1:0] samp_last(input logic [EXP_W-1:0] e);
    return SAMP_W'((32'd1 << e) - 32'd1);
  endfunction

  // Last tick index of one SCL half period for multiplier m.
  function automatic logic [PH_W-1:0] phase_last(input logic [MUL_W-1:0] m);
    return PH_W'(5 * (int'(m) + 1) - 1);
  endfunction

  // Setting that gives an SCL rate at or just below the target.
  function automatic ccr_t default_ccr(input longint sys_hz, input longint scl_hz);
    ccr_t   r;
    longint step;
    longint samp;
    longint div;
    logic   found;
    r     = '1;
    found = 1'b0;
    step  = 10 * scl_hz;
    if (step < 1) step = 1;
    for (int e = 0; e < (1 << EXP_W); e++) begin
      samp = sys_hz >>> e;
      div  = (samp + step - 1) / step;
      if (!found && div <= longint'(1 << MUL_W)) begin
        found = 1'b1;
        if (div < 1) div = 1;
        r.exp = EXP_W'(e);
        r.mul = MUL_W'(div - 1);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/scl_ccr_store.sv
module scl_ccr_store
  import scl_prescale_pkg::*;
#(
  parameter ccr_t RST_CCR = ccr_t'(0)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CCR_W-1:0] wr_data,
  input  logic             load,
  output logic [CCR_W-1:0] held,
  output ccr_t             active
);

  logic [CCR_W-1:0] held_q;
  ccr_t             act_q;

  // Software-visible copy: updated on every write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held_q <= RST_CCR;
    else if (wr_en) held_q <= wr_data;
  end

  // Working copy: only refreshed at a period boundary or while idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= RST_CCR;
    else if (load) act_q <= ccr_t'(held_q);
  end

  assign held   = held_q;
  assign active = act_q;

endmodule

// File: rtl/scl_samp_div.sv
module scl_samp_div
  import scl_prescale_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);

  logic [SAMP_W-1:0] cnt_q;
  logic [SAMP_W-1:0] last;
  logic              wrap;

  assign last = samp_last(exp_sel);
  // >= keeps the count bounded if the exponent shrinks while idle.
  assign wrap = (cnt_q >= last);
  assign tick = enable && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!enable || wrap)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_prescale_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             run,
  input  logic             tick,
  input  logic [MUL_W-1:0] mul_sel,
  output logic             scl,
  output logic             rise,
  output logic             fall,
  output logic             cfg_load
);

  phase_e          st_q;
  logic [PH_W-1:0] cnt_q;
  logic            at_last;
  logic            period_end;

  assign at_last    = (cnt_q == phase_last(mul_sel));
  assign period_end = tick && (st_q == PH_HIGH) && at_last;

  assign scl      = (st_q != PH_LOW);
  assign rise     = tick && (st_q == PH_LOW) && at_last;
  assign fall     = run && ((tick && st_q == PH_IDLE) || period_end);
  assign cfg_load = !enable || (st_q == PH_IDLE) || period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (!enable) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (tick) begin
      case (st_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (run) st_q <= PH_LOW;
        end
        PH_LOW: begin
          if (at_last) begin
            st_q  <= PH_HIGH;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (at_last) begin
            st_q  <= run ? PH_LOW : PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_prescale_pkg::*;
#(
  parameter longint SYSCLK_HZ = 50_000_000,
  parameter longint SCL_HZ    = 100_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       run,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       samp_tick,
  output logic       scl_o,
  output logic       scl_rise,
  output logic       scl_fall
);

  localparam ccr_t RST_CCR = default_ccr(SYSCLK_HZ, SCL_HZ);

  logic [CCR_W-1:0] ccr_held;
  ccr_t             act_ccr;
  logic             cfg_load;
  logic             unused_wbit;

  // Top bit of the write data is reserved.
  assign unused_wbit = cfg_wdata[7];

  scl_ccr_store #(.RST_CCR(RST_CCR)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata[CCR_W-1:0]),
    .load    (cfg_load),
    .held    (ccr_held),
    .active  (act_ccr)
  );

  scl_samp_div u_samp (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .exp_sel (act_ccr.exp),
    .tick    (samp_tick)
  );

  scl_phase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .run      (run),
    .tick     (samp_tick),
    .mul_sel  (act_ccr.mul),
    .scl      (scl_o),
    .rise     (scl_rise),
    .fall     (scl_fall),
    .cfg_load (cfg_load)
  );

  assign cfg_rdata = {1'b0, ccr_held};

endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk
  import scl_prescale_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             cfg_we,
  input logic [6:0]       cfg_wdata,
  input logic [7:0]       cfg_rdata,
  input logic             samp_tick,
  input logic             scl_o,
  input logic             scl_rise,
  input logic             scl_fall,
  input logic [CCR_W-1:0] act_ccr,
  input logic             cfg_load
);

  logic [SAMP_W:0] gap_q;
  logic            reload_seen_q;
  logic [PH_W:0]   low_ticks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q         <= '0;
      reload_seen_q <= 1'b1;
      low_ticks_q   <= '0;
    end else begin
      gap_q         <= (!enable || samp_tick) ? '0 : gap_q + 1'b1;
      reload_seen_q <= (!enable || samp_tick) ? cfg_load : (reload_seen_q | cfg_load);
      if (!enable || scl_rise || scl_fall) low_ticks_q <= '0;
      else if (samp_tick)                  low_ticks_q <= low_ticks_q + 1'b1;
    end
  end

  // R1: a write is visible on the read port one clock later, top bit clear
  p_write_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == {1'b0, $past(cfg_wdata)});

  // R2: sampling strobes spaced by 2^N clocks when N held steady
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_tick && !reload_seen_q) |-> gap_q == {1'b0, samp_last(act_ccr[EXP_W-1:0])});

  // R3: low phase spans 5*(M+1) sampling ticks
  p_low_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> low_ticks_q == {1'b0, phase_last(act_ccr[CCR_W-1:EXP_W])});

  // R5: working setting only changes after a load opportunity
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_ccr) |-> $past(cfg_load));

  // R6: disabled prescaler leaves SCL high
  p_off_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> scl_o);

  // R8: strobes precede the matching SCL edge by one clock
  p_rise_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |=> $rose(scl_o));
  p_fall_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> $fell(scl_o));

endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata[6:0]),
  .cfg_rdata (cfg_rdata),
  .samp_tick (samp_tick),
  .scl_o     (scl_o),
  .scl_rise  (scl_rise),
  .scl_fall  (scl_fall),
  .act_ccr   (act_ccr),
  .cfg_load  (cfg_load)
);

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
  localparam int     CLK_PERIOD = 10;
  localparam longint SYS_HZ     = 50_000_000;
  localparam longint BUS_HZ     = 100_000;
  localparam int     WATCHDOG   = 150_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       run = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       samp_tick, scl_o, scl_rise, scl_fall;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_rate_gen #(.SYSCLK_HZ(SYS_HZ), .SCL_HZ(BUS_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .samp_tick(samp_tick), .scl_o(scl_o), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  // Reset setting derived from R7 in a different form.
  function automatic int expect_default();
    int n;
    int m;
    longint fs;
    n = 7;
    for (int k = 7; k >= 0; k--) begin
      fs = SYS_HZ / (longint'(1) << k);
      if (fs <= 160 * BUS_HZ) n = k;
    end
    fs = SYS_HZ / (longint'(1) << n);
    m = int'((fs + 10 * BUS_HZ - 1) / (10 * BUS_HZ)) - 1;
    if (m < 0) m = 0;
    if (m > 15) m = 15;
    return (m << 3) | n;
  endfunction

  task automatic check(input string tag, input int got, input int exp, input string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ccr, m_n, m_m, m_sc, m_st, m_pc;   // m_st: 0 idle, 1 low, 2 high
  bit cmp_on = 1'b0;

  function automatic bit mdl_tick();
    return enable && (m_sc >= (1 << m_n) - 1);
  endfunction
  function automatic bit mdl_last();
    return m_pc == 5 * (m_m + 1) - 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ccr = expect_default();
      m_n = m_ccr & 7; m_m = m_ccr >> 3;
      m_sc = 0; m_st = 0; m_pc = 0;
    end else begin
      bit t, lst, ld;
      t = mdl_tick();
      lst = mdl_last();
      ld = !enable || m_st == 0 || (t && m_st == 2 && lst);
      if (ld) begin m_n = m_ccr & 7; m_m = m_ccr >> 3; end
      if (!enable) begin
        m_sc = 0; m_st = 0; m_pc = 0;
      end else begin
        m_sc = t ? 0 : m_sc + 1;
        if (t) begin
          if (m_st == 0) begin
            m_pc = 0;
            if (run) m_st = 1;
          end else if (lst) begin
            m_pc = 0;
            m_st = (m_st == 1) ? 2 : (run ? 1 : 0);
          end else begin
            m_pc++;
          end
        end
      end
      if (cfg_we) m_ccr = cfg_wdata & 8'h7F;
    end
  end

  // ---------------- monitor and per-clock compare ----------------
  int  cyc = 0;
  int  last_fall = 0, last_rise = 0, low_len = 0, high_len = 0;
  int  rise_cnt = 0, fall_cnt = 0;
  bit  prev_scl = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      bit t, lst;
      t = mdl_tick();
      lst = mdl_last();
      check("R2", samp_tick, t, "samp_tick vs model");
      check("R3", scl_o, (m_st != 1), "scl_o vs model");
      check("R8", scl_rise, t && m_st == 1 && lst, "scl_rise vs model");
      check("R8", scl_fall, t && run && (m_st == 0 || (m_st == 2 && lst)), "scl_fall vs model");
      check("R1", cfg_rdata, m_ccr, "cfg_rdata vs model");
    end
    if (prev_scl && !scl_o) begin
      high_len = cyc - last_rise; last_fall = cyc; fall_cnt++;
    end
    if (!prev_scl && scl_o) begin
      low_len = cyc - last_fall; last_rise = cyc; rise_cnt++;
    end
    prev_scl = scl_o;
  end

  // ---------------- stimulus helpers ----------------
  task automatic write_cfg(input logic [7:0] v);
    @(posedge clk); #1 cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic wait_rise();
    int s;
    s = rise_cnt;
    wait (rise_cnt != s);
  endtask

  task automatic wait_fall();
    int s;
    s = fall_cnt;
    wait (fall_cnt != s);
  endtask

  task automatic check_phases(input int exp_len, input string tag);
    wait_rise();
    check(tag, low_len, exp_len, "low phase clocks");
    wait_fall();
    check(tag, high_len, exp_len, "high phase clocks");
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int ticks;
    int f0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    // R7: reset setting
    check("R7", cfg_rdata, expect_default(), "reset setting");
    check("R7", cfg_rdata, 8'h62, "reset setting literal");
    check("R6", scl_o, 1, "scl idle after reset");

    // R1: reserved bit ignored
    write_cfg(8'hFF);
    @(negedge clk);
    check("R1", cfg_rdata, 8'h7F, "bit 7 reads zero");

    // R2: N=3, M=2 -> tick every 8 clocks
    write_cfg(8'h13);
    @(posedge clk); #1 enable = 1'b1;
    ticks = 0;
    repeat (64) begin @(negedge clk); if (samp_tick) ticks++; end
    check("R2", ticks, 8, "ticks in 64 clocks at N=3");
    check("R4", fall_cnt, 0, "no SCL activity with run low");

    // R3: N=0, M=0 -> 5-clock phases
    write_cfg(8'h00);
    @(posedge clk); #1 run = 1'b1;
    wait_rise();
    check_phases(5, "R3");

    // R3/R5: switch while running to N=3, M=2 -> 120 clocks
    write_cfg(8'h13);
    wait_rise(); wait_rise();
    check_phases(120, "R3");

    // R5: mid-phase write does not truncate the running period
    wait_fall();
    repeat (10) @(posedge clk);
    write_cfg(8'h09);
    wait_rise();
    check("R5", low_len, 120, "low phase kept after write");
    wait_fall();
    check("R5", high_len, 120, "high phase kept after write");
    wait_rise();
    check("R5", low_len, 20, "new setting at next period");

    // R4: stop at period end, then restart
    @(posedge clk); #1 run = 1'b0;
    repeat (60) @(negedge clk);
    f0 = fall_cnt;
    repeat (200) @(negedge clk);
    check("R4", scl_o, 1, "idle high after run drops");
    check("R4", fall_cnt, f0, "no falls while stopped");
    @(posedge clk); #1 run = 1'b1;
    repeat (4) @(negedge clk);
    check("R4", scl_o, 0, "restart falls at next tick");

    // R6: enable low in a low phase
    wait_fall();
    repeat (3) @(posedge clk);
    #1 enable = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R6", scl_o, 1, "scl high after disable");
    check("R6", samp_tick, 0, "no tick while disabled");
    @(posedge clk); #1 enable = 1'b1;
    check_phases(20, "R6");

    // R3: largest setting N=7, M=15 -> 10240-clock phases
    write_cfg(8'h7F);
    wait_rise(); wait_rise();
    check_phases(10240, "R3");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule